// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This unit gathers single-cycle event pulses raised by the command, data and FIFO engines of a card host controller. Each event is latched in a sticky raw status register. A software-writable enable vector filters the raw status into a masked view. One level interrupt line is driven when any masked bit is set and a global switch is on. Software acknowledges an event by writing a one to its raw bit.

Two summary outputs group the masked bits into failures and completions. A third output, `finish_o`, tells the request handler that the current command may be closed. It stays low while a response timeout is pending without its matching command-done event. This is because the engine still reports command done after a timeout, and closing early would leave a stale event behind.

The register port has no wait states. Writes take effect at the clock edge. Read data is a combinational function of the address and the current register contents. The four word addresses are: 0 raw status (write one to clear), 1 masked status (read only), 2 enable vector (read/write), 3 control (bit 0 = global interrupt enable).

Top module: `card_irq_status`

## Requirements
- R1: After a synchronous active-low reset, the raw status, enable vector and global enable read as zero, and `irq_o`, `err_sum_o`, `done_sum_o` and `finish_o` are low.
- R2: A pulse on `evt_i[b]` at a clock edge sets raw bit b from the next cycle on, and the bit stays set until it is cleared. The live positions are: 1 response error, 2 command done, 3 data over, 4 TX request, 5 RX request, 6 response CRC error, 7 data CRC error, 8 response timeout, 9 data timeout, 10 voltage switch done, 11 FIFO run error, 12 hardware locked, 13 start-bit error, 14 auto-command done, 15 end-bit error, 16 card-side interrupt, 30 card inserted, 31 card removed.
- R3: Raw bits 0 and 17 to 29 always read zero, whatever pulses arrive (live mask 0xC001FFFE).
- R4: A write to address 0 clears each raw bit whose data bit is 1 and leaves raw bits with data bit 0 unchanged.
- R5: If an event pulse and a clearing write hit the same bit at the same edge, the bit ends up set.
- R6: Address 1 reads the raw status ANDed with the enable vector.
- R7: `irq_o` is high exactly when the global enable (address 3, bit 0) is 1 and at least one masked bit is set.
- R8: `err_sum_o` is the OR of masked bits 1, 6, 7, 8, 9, 11, 12, 13 and 15 (mask 0x0000BBC2).
- R9: `done_sum_o` is the OR of masked bits 2, 3, 10 and 14 (mask 0x0000440C).
- R10: `finish_o` is high when `err_sum_o` or `done_sum_o` is high, except while masked bit 8 (response timeout) is set and masked bit 2 (command done) is clear.
- R11: Writes to address 1 change no register.
- R12: Address 2 reads back the last written 32-bit enable vector. Address 3 stores only data bit 0 and reads zero in bits 31 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per status position |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt level |
| err_sum_o | output | 1 | Any masked failure event |
| done_sum_o | output | 1 | Any masked completion event |
| finish_o | output | 1 | Request may be closed |

## Verification
Some properties are checked on every cycle by assertions. These are: the set-next-cycle and clear-next-cycle behaviour of each live status bit, the zero read of dead positions, the rule that the interrupt never rises with the global switch off, and the rule that `finish_o` never coexists with a timeout lacking its command done. Other behaviours can only be shown by the bench's scenarios, compared against a behavioural model. These are: the set-wins collision of an event with a clear, the read-only masked address, the single-bit control register, and the timeout-then-command-done completion order.

// File: rtl/isu_pkg.sv
// Package: shared widths, status bit positions, group masks and the
// register address map of the interrupt status unit.
package isu_pkg;

    localparam int unsigned STAT_W = 32;
    localparam int unsigned ADDR_W = 2;

    // Status bit positions (consumed by the event engines and software).
    localparam int unsigned B_RSP_ERR   = 1;
    localparam int unsigned B_CMD_DONE  = 2;
    localparam int unsigned B_DAT_OVER  = 3;
    localparam int unsigned B_TX_REQ    = 4;
    localparam int unsigned B_RX_REQ    = 5;
    localparam int unsigned B_RSP_CRC   = 6;
    localparam int unsigned B_DAT_CRC   = 7;
    localparam int unsigned B_RSP_TO    = 8;
    localparam int unsigned B_DAT_TO    = 9;
    localparam int unsigned B_VSW_DONE  = 10;
    localparam int unsigned B_FIFO_RUN  = 11;
    localparam int unsigned B_HW_LOCK   = 12;
    localparam int unsigned B_SBIT_ERR  = 13;
    localparam int unsigned B_AUTO_DONE = 14;
    localparam int unsigned B_EBIT_ERR  = 15;
    localparam int unsigned B_CARD_IRQ  = 16;
    localparam int unsigned B_CARD_IN   = 30;
    localparam int unsigned B_CARD_OUT  = 31;

    // Failure group.
    localparam logic [STAT_W-1:0] ERR_GROUP =
        (STAT_W'(1) << B_RSP_ERR)  | (STAT_W'(1) << B_RSP_CRC)  |
        (STAT_W'(1) << B_DAT_CRC)  | (STAT_W'(1) << B_RSP_TO)   |
        (STAT_W'(1) << B_DAT_TO)   | (STAT_W'(1) << B_FIFO_RUN) |
        (STAT_W'(1) << B_HW_LOCK)  | (STAT_W'(1) << B_SBIT_ERR) |
        (STAT_W'(1) << B_EBIT_ERR);

    // Completion group.
    localparam logic [STAT_W-1:0] DONE_GROUP =
        (STAT_W'(1) << B_CMD_DONE) | (STAT_W'(1) << B_DAT_OVER) |
        (STAT_W'(1) << B_VSW_DONE) | (STAT_W'(1) << B_AUTO_DONE);

    // Positions that own a storage flop.
    localparam logic [STAT_W-1:0] LIVE_MASK =
        ERR_GROUP | DONE_GROUP |
        (STAT_W'(1) << B_TX_REQ)   | (STAT_W'(1) << B_RX_REQ)   |
        (STAT_W'(1) << B_CARD_IRQ) | (STAT_W'(1) << B_CARD_IN)  |
        (STAT_W'(1) << B_CARD_OUT);

    typedef enum logic [ADDR_W-1:0] {
        SEL_RAW    = 2'd0,
        SEL_MASKED = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/isu_status_bit.sv
// One sticky status flop.
// Sets on an event pulse, clears on a software clear strobe.
// Assumes: when both arrive at the same edge, the event wins.
module isu_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Sticky flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/isu_cfg_regs.sv
// Enable vector and global interrupt switch.
// Assumes: single-cycle writes; the address 3 register keeps only data bit 0.
module isu_cfg_regs
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] enable_o,
    output logic              gie_o
);

    logic wr_enable;
    logic wr_ctrl;

    // Address decode for the two writable configuration words.
    always_comb begin
        wr_enable = wr_en_i && (reg_sel_e'(addr_i) == SEL_ENABLE);
        wr_ctrl   = wr_en_i && (reg_sel_e'(addr_i) == SEL_CTRL);
    end

    // Configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o <= '0;
            gie_o    <= 1'b0;
        end else begin
            if (wr_enable) enable_o <= wr_data_i;
            if (wr_ctrl)   gie_o    <= wr_data_i[0];
        end
    end

endmodule

// File: rtl/isu_summary.sv
// Group decode of the masked status.
// Produces the failure OR, the completion OR and the close-request flag.
// The close-request flag is held off while a response timeout still
// awaits its command done.
module isu_summary
    import isu_pkg::*;
(
    input  logic [STAT_W-1:0] masked_i,
    output logic              err_o,
    output logic              done_o,
    output logic              finish_o
);

    logic to_pending;
    logic unused_bits;

    assign unused_bits = ^(masked_i & ~(ERR_GROUP | DONE_GROUP));

    // Group ORs and the timeout-waits-for-command-done gate.
    always_comb begin
        err_o      = |(masked_i & ERR_GROUP);
        done_o     = |(masked_i & DONE_GROUP);
        to_pending = masked_i[B_RSP_TO] && !masked_i[B_CMD_DONE];
        finish_o   = (err_o || done_o) && !to_pending;
    end

endmodule

// File: rtl/card_irq_status.sv
// Top of the interrupt status unit.
// Holds the raw event register (write one to clear), the masked view,
// the interrupt line and the group summaries.
// Assumes: event pulses and the register port share one clock.
module card_irq_status
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              err_sum_o,
    output logic              done_sum_o,
    output logic              finish_o
);

    logic [STAT_W-1:0] raw_q;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] enable_q;
    logic [STAT_W-1:0] masked;
    logic              gie_q;
    logic              unused_dead;

    // Clear strobes come from a write to the raw address.
    always_comb begin
        clr_vec = (wr_en_i && (reg_sel_e'(addr_i) == SEL_RAW)) ? wr_data_i : '0;
    end

    // One flop per live position; dead positions are tied low.
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (LIVE_MASK[b]) begin : g_live
            isu_status_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (evt_i[b]),
                .clr_i (clr_vec[b]),
                .q_o   (raw_q[b])
            );
        end else begin : g_dead
            assign raw_q[b] = 1'b0;
        end
    end

    assign unused_dead = ^((evt_i | clr_vec) & ~LIVE_MASK);

    isu_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .enable_o  (enable_q),
        .gie_o     (gie_q)
    );

    // Masked view and interrupt level.
    always_comb begin
        masked = raw_q & enable_q;
        irq_o  = gie_q && (|masked);
    end

    isu_summary u_sum (
        .masked_i (masked),
        .err_o    (err_sum_o),
        .done_o   (done_sum_o),
        .finish_o (finish_o)
    );

    // Read multiplexer.
    always_comb begin
        case (reg_sel_e'(addr_i))
            SEL_RAW:    rd_data_o = raw_q;
            SEL_MASKED: rd_data_o = masked;
            SEL_ENABLE: rd_data_o = enable_q;
            default:    rd_data_o = {{(STAT_W-1){1'b0}}, gie_q};
        endcase
    end

    assert_dead_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_e'(addr_i) == SEL_RAW) |-> ((rd_data_o & ~LIVE_MASK) == '0));

    assert_irq_needs_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_q);

    assert_finish_after_cmd_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_o && masked[B_RSP_TO]) |-> masked[B_CMD_DONE]);

    assert_finish_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |-> (err_sum_o || done_sum_o));

endmodule

// File: tb/card_irq_status_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge and
// compared on every falling edge, plus directed scenario checks.
module card_irq_status_test;

    localparam logic [31:0] LIVE = 32'hC001FFFE;
    localparam logic [31:0] ERRM = 32'h0000BBC2;
    localparam logic [31:0] DONM = 32'h0000440C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        irq, err_sum, done_sum, finish;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit ended = 1'b0;

    logic [31:0] m_raw, m_en_vec;
    logic        m_gie;

    always #2 clk = ~clk;

    card_irq_status uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data),
        .irq_o(irq), .err_sum_o(err_sum), .done_sum_o(done_sum),
        .finish_o(finish)
    );

    // Reference model state update.
    always @(posedge clk) begin
        logic [31:0] clr;
        if (!rst_n) begin
            m_raw = '0; m_en_vec = '0; m_gie = 1'b0;
        end else begin
            clr = (wr_en && addr == 2'd0) ? wdata : '0;
            m_raw = ((m_raw & ~clr) | evt) & LIVE;
            if (wr_en && addr == 2'd2) m_en_vec = wdata;
            if (wr_en && addr == 2'd3) m_gie = wdata[0];
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        logic [31:0] mk, erd;
        logic e_err, e_don;
        if (cmp_on) begin
            mk = m_raw & m_en_vec;
            e_err = |(mk & ERRM);
            e_don = |(mk & DONM);
            case (addr)
                2'd0: erd = m_raw;
                2'd1: erd = mk;
                2'd2: erd = m_en_vec;
                default: erd = {31'b0, m_gie};
            endcase
            cmp("R7 irq", {31'b0, irq}, {31'b0, m_gie && (|mk)});
            cmp("R8 err_sum", {31'b0, err_sum}, {31'b0, e_err});
            cmp("R9 done_sum", {31'b0, done_sum}, {31'b0, e_don});
            cmp("R10 finish", {31'b0, finish},
                {31'b0, (e_err || e_don) && !(mk[8] && !mk[2])});
            case (addr)
                2'd0: cmp("R2,R3,R4,R5 raw read", rd_data, erd);
                2'd1: cmp("R6,R11 masked read", rd_data, erd);
                default: cmp("R12 config read", rd_data, erd);
            endcase
        end
    end

    task automatic step(input logic [31:0] e, input logic w, input logic [1:0] a,
                        input logic [31:0] d);
        @(posedge clk); #1;
        evt = e; wr_en = w; addr = a; wdata = d;
    endtask

    // Idle cycle with the read address set, then sample at the falling edge.
    task automatic look(input logic [1:0] a);
        step('0, 1'b0, a, '0);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) step('0, 1'b0, 2'd0, '0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        look(2'd0); cmp("R1 raw after reset", rd_data, '0);
        cmp("R1 irq after reset", {31'b0, irq}, '0);
        look(2'd2); cmp("R1 enable after reset", rd_data, '0);
        look(2'd3); cmp("R1 ctrl after reset", rd_data, '0);

        step('0, 1'b1, 2'd2, 32'hFFFFFFFF);
        step('0, 1'b1, 2'd3, 32'hFFFFFFFF);
        look(2'd3); cmp("R12 ctrl keeps bit 0 only", rd_data, 32'h1);

        // R10: timeout alone holds off finish, then command done releases it
        step(32'h100, 1'b0, 2'd0, '0);
        look(2'd0);
        cmp("R10 timeout alone: finish", {31'b0, finish}, '0);
        cmp("R8 timeout sets err_sum", {31'b0, err_sum}, 32'h1);
        step(32'h4, 1'b0, 2'd0, '0);
        look(2'd0);
        cmp("R10 timeout+cmd done: finish", {31'b0, finish}, 32'h1);

        // R4 full clear
        step('0, 1'b1, 2'd0, 32'hFFFFFFFF);
        look(2'd0); cmp("R4 clear all", rd_data, '0);
        cmp("R7 irq after clear", {31'b0, irq}, '0);

        // R2 / R3 all pulses
        step(32'hFFFFFFFF, 1'b0, 2'd0, '0);
        look(2'd0); cmp("R2,R3 all events", rd_data, 32'hC001FFFE);
        look(2'd0); cmp("R2 sticky", rd_data, 32'hC001FFFE);

        // R4 partial clear
        step('0, 1'b1, 2'd0, 32'h0000_0002);
        look(2'd0); cmp("R4 clear bit1 only", rd_data, 32'hC001FFFC);

        // R5 collision: event and clear on bit 5
        step(32'h20, 1'b1, 2'd0, 32'h20);
        look(2'd0); cmp("R5 set wins", rd_data & 32'h20, 32'h20);

        // R11 write to masked address ignored
        step('0, 1'b1, 2'd1, '0);
        look(2'd1); cmp("R11 masked unchanged", rd_data, 32'hC001FFFC);
        look(2'd2); cmp("R11 enable unchanged", rd_data, 32'hFFFFFFFF);

        // R6 narrow enable vector
        step('0, 1'b1, 2'd2, 32'h0000_0004);
        look(2'd1); cmp("R6 masked view", rd_data, 32'h4);
        cmp("R9 done via cmd done", {31'b0, done_sum}, 32'h1);
        cmp("R8 err masked off", {31'b0, err_sum}, '0);

        // R7 global switch off
        step('0, 1'b1, 2'd3, '0);
        look(2'd1); cmp("R7 gie off silences irq", {31'b0, irq}, '0);
        step('0, 1'b1, 2'd3, 32'h1);
        look(2'd1); cmp("R7 gie on raises irq", {31'b0, irq}, 32'h1);

        // R9 auto-command done alone
        step('0, 1'b1, 2'd0, 32'hFFFFFFFF);
        step('0, 1'b1, 2'd2, 32'hFFFFFFFF);
        step(32'h4000, 1'b0, 2'd0, '0);
        look(2'd0);
        cmp("R9 auto done", {31'b0, done_sum}, 32'h1);
        cmp("R10 finish on done", {31'b0, finish}, 32'h1);
        cmp("R8 no error", {31'b0, err_sum}, '0);

        // Mixed traffic checked by the model every cycle
        for (int i = 0; i < 600; i++) begin
            logic [31:0] e;
            e = $urandom() & $urandom() & $urandom() & $urandom();
            step(e, ($urandom() % 4) == 0, 2'($urandom()),
                 ($urandom() % 2) ? $urandom() : ($urandom() & $urandom()));
        end
        look(2'd0);
        finish_run();
    end

endmodule